// File: doc/BRIEF.md
# Machine Cycle Timing Sequencer

This block is the timing core of a small 8-bit controller. It runs on the oscillator clock. Every machine cycle is made of six states, and each state has two phases that last one oscillator period each, so a machine cycle is twelve clocks long. Each clock the block reports which state and phase it is in. From that position it generates the strobes the rest of the core depends on:

- the instruction-register latch pulse;
- the two program-fetch slots of every machine cycle;
- the address-latch pulses;
- the program-store read strobe;
- the program-counter increment enable;
- an end-of-instruction pulse.

The instruction decoder tells the block how long the current instruction is, in bytes and in machine cycles, and whether it is an external data move. The block samples these attributes once, one clock after the opcode latch. A fetch slot whose byte the instruction does not need still occurs, but it does not advance the program counter. The second machine cycle of an external data move issues no program fetch and no program read strobe. The address-latch pulse in its first state is also dropped.

The phase machine has twelve states, T_S1P1 through T_S6P2. It advances one state per clock and wraps from T_S6P2 back to T_S1P1. The cycle machine has three states: CY_FIRST, CY_CODE2 (second cycle of a code-only instruction) and CY_XDAT2 (second cycle of an external data move). It changes state only at T_S6P2:
- CY_FIRST goes to CY_CODE2 or CY_XDAT2 when the instruction needs two cycles. Otherwise it stays in CY_FIRST.
- Both second-cycle states return to CY_FIRST.

Top module: `mcyc_sequencer`

## Requirements
- R1: While reset is low, and after any reset, the block sits in state 1 phase 1 of a first machine cycle: state_o=0, phase_o=0, second_cyc_o=0, and ir_latch_o=1.
- R2: phase_o toggles every clock (0 = first half, 1 = second half). state_o advances by one after each second half, taking the values 0 to 5 (meaning states 1 to 6). It wraps from 5 back to 0, so a machine cycle is 12 clocks.
- R3: ir_latch_o is high for exactly one clock per instruction: state 1 phase 1 of its first machine cycle.
- R4: fetch_o is high in state 1 phase 1 and in state 4 phase 1 of every machine cycle, except in the second cycle of an external data move, where it stays low.
- R5: pc_inc_o is high in these fetch slots only: state 1 of cycle one always; state 4 of cycle one when op_len_i is 2 or 3; state 1 of cycle two when op_len_i is 3. op_len_i=0 counts as 1.
- R6: ale_o is high in state 1 phase 2 and in state 4 phase 2. The state 1 pulse is dropped in the second cycle of an external data move.
- R7: prog_rd_o is high for both phases of states 2 and 5, four clocks per cycle. It stays low for the whole second cycle of an external data move.
- R8: An instruction takes two machine cycles when op_two_cyc_i=1, op_xdata_i=1 or op_len_i=3, and one cycle otherwise. second_cyc_o is high during all 12 clocks of the second cycle.
- R9: instr_done_o is high for one clock, in state 6 phase 2 of the instruction's last machine cycle.
- R10: op_len_i, op_two_cyc_i and op_xdata_i are sampled only at the end of state 1 phase 2 of a first cycle. Changes at any other time have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Oscillator clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| op_len_i | input | 2 | Instruction length in bytes (0/1, 2, 3) |
| op_two_cyc_i | input | 1 | Decoder marks instruction as two machine cycles |
| op_xdata_i | input | 1 | Instruction is an external data move |
| state_o | output | 3 | Current state, 0..5 for states 1..6 |
| phase_o | output | 1 | Current phase, 0 first half, 1 second half |
| ir_latch_o | output | 1 | Opcode latch strobe |
| fetch_o | output | 1 | Program fetch slot |
| pc_inc_o | output | 1 | Program counter increment enable |
| ale_o | output | 1 | Address latch strobe |
| prog_rd_o | output | 1 | Program store read strobe |
| second_cyc_o | output | 1 | Second machine cycle in progress |
| instr_done_o | output | 1 | Last clock of the instruction |

## Verification
The hardest situation to reach is the second cycle of an external data move. It can only be entered when the decoder attributes are held correctly across the single sampling clock. Its effect also shows up only as missing strobes, spread over twelve clocks. The stimulus aligns itself to each opcode latch and drives the attributes there. It then deliberately scrambles them from the third clock on, so that both the sampling window and the suppression are exercised. It records every strobe as a per-clock bit mask over the whole instruction and compares each mask against a table. A reset is also applied part-way through a second cycle to confirm the return to the first state.

// File: rtl/mcyc_pkg.sv
`timescale 1ns/1ps
package mcyc_pkg;

    localparam int unsigned STATES_PER_CYCLE = 6;
    localparam int unsigned PHASES_PER_STATE = 2;
    localparam int unsigned TICKS_PER_CYCLE  = STATES_PER_CYCLE * PHASES_PER_STATE;
    localparam int unsigned STATE_W          = $clog2(STATES_PER_CYCLE);

    typedef enum logic [3:0] {
        T_S1P1 = 4'd0,
        T_S1P2,
        T_S2P1,
        T_S2P2,
        T_S3P1,
        T_S3P2,
        T_S4P1,
        T_S4P2,
        T_S5P1,
        T_S5P2,
        T_S6P1,
        T_S6P2
    } tick_e;

    typedef enum logic [1:0] {
        CY_FIRST = 2'd0,
        CY_CODE2 = 2'd1,
        CY_XDAT2 = 2'd2
    } cyc_e;

endpackage

// File: rtl/mcyc_phase_fsm.sv
`timescale 1ns/1ps
module mcyc_phase_fsm
    import mcyc_pkg::*;
#(
    parameter int unsigned ST_W = STATE_W
) (
    input  logic            clk_i,
    input  logic            rst_ni,
    output tick_e           tick_o,
    output logic [ST_W-1:0] state_o,
    output logic            phase_o
);

    tick_e tick_q, tick_d;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) tick_q <= T_S1P1;
        else         tick_q <= tick_d;
    end

    always_comb begin
        tick_d = T_S1P1;
        unique case (tick_q)
            T_S1P1:  tick_d = T_S1P2;
            T_S1P2:  tick_d = T_S2P1;
            T_S2P1:  tick_d = T_S2P2;
            T_S2P2:  tick_d = T_S3P1;
            T_S3P1:  tick_d = T_S3P2;
            T_S3P2:  tick_d = T_S4P1;
            T_S4P1:  tick_d = T_S4P2;
            T_S4P2:  tick_d = T_S5P1;
            T_S5P1:  tick_d = T_S5P2;
            T_S5P2:  tick_d = T_S6P1;
            T_S6P1:  tick_d = T_S6P2;
            T_S6P2:  tick_d = T_S1P1;
            default: tick_d = T_S1P1;
        endcase
    end

    always_comb begin
        state_o = '0;
        phase_o = 1'b0;
        unique case (tick_q)
            T_S1P1:  begin state_o = ST_W'(0); phase_o = 1'b0; end
            T_S1P2:  begin state_o = ST_W'(0); phase_o = 1'b1; end
            T_S2P1:  begin state_o = ST_W'(1); phase_o = 1'b0; end
            T_S2P2:  begin state_o = ST_W'(1); phase_o = 1'b1; end
            T_S3P1:  begin state_o = ST_W'(2); phase_o = 1'b0; end
            T_S3P2:  begin state_o = ST_W'(2); phase_o = 1'b1; end
            T_S4P1:  begin state_o = ST_W'(3); phase_o = 1'b0; end
            T_S4P2:  begin state_o = ST_W'(3); phase_o = 1'b1; end
            T_S5P1:  begin state_o = ST_W'(4); phase_o = 1'b0; end
            T_S5P2:  begin state_o = ST_W'(4); phase_o = 1'b1; end
            T_S6P1:  begin state_o = ST_W'(5); phase_o = 1'b0; end
            T_S6P2:  begin state_o = ST_W'(5); phase_o = 1'b1; end
            default: begin state_o = '0;       phase_o = 1'b0; end
        endcase
    end

    assign tick_o = tick_q;

    // R2: the half alternates on every clock
    p_phase_alt_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        1'b1 |=> (phase_o != $past(phase_o)));

    // R2: the last half of state 6 is followed by the first half of state 1
    p_wrap_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (tick_q == T_S6P2) |=> (state_o == '0 && !phase_o));

    // R2: the state number stays in range
    p_range_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        state_o < ST_W'(STATES_PER_CYCLE));

endmodule

// File: rtl/mcyc_cycle_fsm.sv
`timescale 1ns/1ps
module mcyc_cycle_fsm
    import mcyc_pkg::*;
#(
    parameter int unsigned LEN_W = 2
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  tick_e            tick_i,
    input  logic [LEN_W-1:0] op_len_i,
    input  logic             op_two_cyc_i,
    input  logic             op_xdata_i,
    output cyc_e             cyc_o,
    output logic [LEN_W-1:0] len_o,
    output logic             two_o
);

    localparam logic [LEN_W-1:0] LEN_LONG = LEN_W'(3);

    cyc_e             cyc_q, cyc_d;
    logic [LEN_W-1:0] len_q;
    logic             two_q, xd_q;
    logic             capture;

    assign capture = (tick_i == T_S1P2) && (cyc_q == CY_FIRST);

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) cyc_q <= CY_FIRST;
        else         cyc_q <= cyc_d;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            len_q <= '0;
            two_q <= 1'b0;
            xd_q  <= 1'b0;
        end else if (capture) begin
            len_q <= op_len_i;
            xd_q  <= op_xdata_i;
            two_q <= op_two_cyc_i | op_xdata_i | (op_len_i == LEN_LONG);
        end
    end

    always_comb begin
        cyc_d = cyc_q;
        if (tick_i == T_S6P2) begin
            unique case (cyc_q)
                CY_FIRST: cyc_d = two_q ? (xd_q ? CY_XDAT2 : CY_CODE2) : CY_FIRST;
                CY_CODE2: cyc_d = CY_FIRST;
                CY_XDAT2: cyc_d = CY_FIRST;
                default:  cyc_d = CY_FIRST;
            endcase
        end
    end

    assign cyc_o = cyc_q;
    assign len_o = len_q;
    assign two_o = two_q;

    // R8: the cycle kind changes only at the end of a machine cycle
    p_cyc_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (tick_i != T_S6P2) |=> $stable(cyc_q));

    // R8: a second cycle is always followed by a first cycle
    p_second_ends_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (tick_i == T_S6P2 && cyc_q != CY_FIRST) |=> (cyc_q == CY_FIRST));

    // R10: attributes move only in the sampling slot
    p_attr_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !capture |=> ($stable(len_q) && $stable(two_q) && $stable(xd_q)));

endmodule

// File: rtl/mcyc_strobe_dec.sv
`timescale 1ns/1ps
module mcyc_strobe_dec
    import mcyc_pkg::*;
#(
    parameter int unsigned LEN_W = 2
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  tick_e            tick_i,
    input  cyc_e             cyc_i,
    input  logic [LEN_W-1:0] len_i,
    input  logic             two_i,
    output logic             ir_latch_o,
    output logic             fetch_o,
    output logic             pc_inc_o,
    output logic             ale_o,
    output logic             prog_rd_o,
    output logic             second_cyc_o,
    output logic             instr_done_o
);

    localparam logic [LEN_W-1:0] LEN_TWO  = LEN_W'(2);
    localparam logic [LEN_W-1:0] LEN_LONG = LEN_W'(3);

    logic first_c, xdat2_c, code2_c;

    assign first_c = (cyc_i == CY_FIRST);
    assign xdat2_c = (cyc_i == CY_XDAT2);
    assign code2_c = (cyc_i == CY_CODE2);

    always_comb begin
        ir_latch_o   = 1'b0;
        fetch_o      = 1'b0;
        pc_inc_o     = 1'b0;
        ale_o        = 1'b0;
        prog_rd_o    = 1'b0;
        instr_done_o = 1'b0;
        unique case (tick_i)
            T_S1P1: begin
                ir_latch_o = first_c;
                fetch_o    = !xdat2_c;
                pc_inc_o   = first_c | (code2_c && len_i == LEN_LONG);
            end
            T_S1P2:         ale_o     = !xdat2_c;
            T_S2P1, T_S2P2: prog_rd_o = !xdat2_c;
            T_S4P1: begin
                fetch_o  = !xdat2_c;
                pc_inc_o = first_c && (len_i >= LEN_TWO);
            end
            T_S4P2:         ale_o     = 1'b1;
            T_S5P1, T_S5P2: prog_rd_o = !xdat2_c;
            T_S6P2:         instr_done_o = !first_c | !two_i;
            default: ;
        endcase
    end

    assign second_cyc_o = !first_c;

    // R7: fetch slot, address latch and read strobe never overlap
    p_excl_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $onehot0({fetch_o, ale_o, prog_rd_o}));

    // R5: the counter only advances in a fetch slot
    p_pci_fetch_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        pc_inc_o |-> fetch_o);

    // R3: the opcode latch never fires in a second cycle
    p_ir_first_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ir_latch_o |-> !second_cyc_o);

endmodule

// File: rtl/mcyc_sequencer.sv
`timescale 1ns/1ps
module mcyc_sequencer
    import mcyc_pkg::*;
#(
    parameter int unsigned LEN_W = 2
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic [LEN_W-1:0] op_len_i,
    input  logic             op_two_cyc_i,
    input  logic             op_xdata_i,
    output logic [2:0]       state_o,
    output logic             phase_o,
    output logic             ir_latch_o,
    output logic             fetch_o,
    output logic             pc_inc_o,
    output logic             ale_o,
    output logic             prog_rd_o,
    output logic             second_cyc_o,
    output logic             instr_done_o
);

    tick_e            tick_w;
    cyc_e             cyc_w;
    logic [LEN_W-1:0] len_w;
    logic             two_w;

    mcyc_phase_fsm #(.ST_W(3)) u_phase (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .tick_o  (tick_w),
        .state_o (state_o),
        .phase_o (phase_o)
    );

    mcyc_cycle_fsm #(.LEN_W(LEN_W)) u_cycle (
        .clk_i        (clk_i),
        .rst_ni       (rst_ni),
        .tick_i       (tick_w),
        .op_len_i     (op_len_i),
        .op_two_cyc_i (op_two_cyc_i),
        .op_xdata_i   (op_xdata_i),
        .cyc_o        (cyc_w),
        .len_o        (len_w),
        .two_o        (two_w)
    );

    mcyc_strobe_dec #(.LEN_W(LEN_W)) u_strobe (
        .clk_i        (clk_i),
        .rst_ni       (rst_ni),
        .tick_i       (tick_w),
        .cyc_i        (cyc_w),
        .len_i        (len_w),
        .two_i        (two_w),
        .ir_latch_o   (ir_latch_o),
        .fetch_o      (fetch_o),
        .pc_inc_o     (pc_inc_o),
        .ale_o        (ale_o),
        .prog_rd_o    (prog_rd_o),
        .second_cyc_o (second_cyc_o),
        .instr_done_o (instr_done_o)
    );

    // R4: no program fetch or read strobe in an external data cycle
    p_xd_quiet_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cyc_w == CY_XDAT2) |-> (!fetch_o && !prog_rd_o));

    // R9: an instruction end is followed by the next opcode latch
    p_done_next_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        instr_done_o |=> ir_latch_o);

    // R9: end of instruction only in the last half of state 6
    p_done_slot_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        instr_done_o |-> (state_o == 3'd5 && phase_o));

endmodule

// File: tb/sim_mcyc_sequencer.sv
`timescale 1ns/1ps
module sim_mcyc_sequencer;

    typedef struct packed {
        logic [1:0]  len;
        logic        two;
        logic        xd;
        logic [23:0] fet;
        logic [23:0] ale;
        logic [23:0] prd;
        logic [23:0] pci;
        logic [23:0] sec;
        logic [23:0] done;
    } vec_t;

    localparam int NV = 9;
    // expected per-clock masks, bit k = k-th clock after the opcode latch
    localparam vec_t VT [NV] = '{
        '{2'd1, 1'b0, 1'b0, 24'h000041, 24'h000082, 24'h00030C, 24'h000001, 24'h000000, 24'h000800},
        '{2'd2, 1'b0, 1'b0, 24'h000041, 24'h000082, 24'h00030C, 24'h000041, 24'h000000, 24'h000800},
        '{2'd1, 1'b1, 1'b0, 24'h041041, 24'h082082, 24'h30C30C, 24'h000001, 24'hFFF000, 24'h800000},
        '{2'd3, 1'b0, 1'b0, 24'h041041, 24'h082082, 24'h30C30C, 24'h001041, 24'hFFF000, 24'h800000},
        '{2'd3, 1'b1, 1'b0, 24'h041041, 24'h082082, 24'h30C30C, 24'h001041, 24'hFFF000, 24'h800000},
        '{2'd1, 1'b0, 1'b1, 24'h000041, 24'h080082, 24'h00030C, 24'h000001, 24'hFFF000, 24'h800000},
        '{2'd2, 1'b1, 1'b0, 24'h041041, 24'h082082, 24'h30C30C, 24'h000041, 24'hFFF000, 24'h800000},
        '{2'd0, 1'b0, 1'b0, 24'h000041, 24'h000082, 24'h00030C, 24'h000001, 24'h000000, 24'h000800},
        '{2'd2, 1'b0, 1'b1, 24'h000041, 24'h080082, 24'h00030C, 24'h000041, 24'hFFF000, 24'h800000}
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] op_len = 2'd0;
    logic       op_two = 1'b0;
    logic       op_xd = 1'b0;
    logic [2:0] state_o;
    logic       phase_o, ir_latch_o, fetch_o, pc_inc_o, ale_o, prog_rd_o;
    logic       second_cyc_o, instr_done_o;

    int checks = 0;
    int errs = 0;

    always #2.5 clk = ~clk;

    mcyc_sequencer u0 (
        .clk_i        (clk),
        .rst_ni       (rst_n),
        .op_len_i     (op_len),
        .op_two_cyc_i (op_two),
        .op_xdata_i   (op_xd),
        .state_o      (state_o),
        .phase_o      (phase_o),
        .ir_latch_o   (ir_latch_o),
        .fetch_o      (fetch_o),
        .pc_inc_o     (pc_inc_o),
        .ale_o        (ale_o),
        .prog_rd_o    (prog_rd_o),
        .second_cyc_o (second_cyc_o),
        .instr_done_o (instr_done_o)
    );

    task automatic chk(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errs++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errs++;
        checks++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin
        logic [23:0] m_fet, m_ale, m_prd, m_pci, m_sec, m_done, m_ir;
        logic seen;

        // R1: reset state
        repeat (3) @(negedge clk);
        chk(state_o == 3'd0 && !phase_o, "R1 reset position", {state_o, phase_o}, 0);
        chk(ir_latch_o && !second_cyc_o && !instr_done_o, "R1 reset strobes",
            {ir_latch_o, second_cyc_o, instr_done_o}, 3'b100);
        rst_n = 1'b1;

        // R2: state/phase sequence through one cycle and the wrap
        for (int k = 0; k <= 12; k++) begin
            if (k > 0) @(negedge clk);
            chk(state_o == 3'((k % 12) / 2) && phase_o == (k % 2 == 1), "R2 sequence",
                {state_o, phase_o}, {3'((k % 12) / 2), 1'(k % 2)});
        end

        // table walk: R3..R10
        for (int i = 0; i < NV; i++) begin
            do @(negedge clk); while (!ir_latch_o);
            op_len = VT[i].len;
            op_two = VT[i].two;
            op_xd  = VT[i].xd;
            m_fet = '0; m_ale = '0; m_prd = '0; m_pci = '0; m_sec = '0; m_done = '0; m_ir = '0;
            seen = 1'b0;
            for (int k = 0; k < 24; k++) begin
                if (k > 0) begin
                    if (seen) break;
                    @(negedge clk);
                end
                if (k == 2) begin
                    // R10: inputs changed after the sampling slot must not matter
                    op_len = ~VT[i].len;
                    op_two = ~VT[i].two;
                    op_xd  = ~VT[i].xd;
                end
                m_fet[k]  = fetch_o;
                m_ale[k]  = ale_o;
                m_prd[k]  = prog_rd_o;
                m_pci[k]  = pc_inc_o;
                m_sec[k]  = second_cyc_o;
                m_done[k] = instr_done_o;
                m_ir[k]   = ir_latch_o;
                if (instr_done_o) seen = 1'b1;
            end
            chk(m_ir == 24'h1, "R3 opcode latch", 32'(m_ir), 32'h1);
            chk(m_fet == VT[i].fet, "R4 fetch slots (R10)", 32'(m_fet), 32'(VT[i].fet));
            chk(m_pci == VT[i].pci, "R5 pc increment (R10)", 32'(m_pci), 32'(VT[i].pci));
            chk(m_ale == VT[i].ale, "R6 address latch", 32'(m_ale), 32'(VT[i].ale));
            chk(m_prd == VT[i].prd, "R7 read strobe", 32'(m_prd), 32'(VT[i].prd));
            chk(m_sec == VT[i].sec, "R8 second cycle", 32'(m_sec), 32'(VT[i].sec));
            chk(m_done == VT[i].done, "R9 end pulse", 32'(m_done), 32'(VT[i].done));
        end

        // R1: reset in the middle of a second cycle
        do @(negedge clk); while (!ir_latch_o);
        op_len = 2'd1; op_two = 1'b1; op_xd = 1'b0;
        repeat (15) @(negedge clk);
        chk(second_cyc_o, "R8 mid second cycle", {31'd0, second_cyc_o}, 1);
        rst_n = 1'b0;
        #1;
        chk(state_o == 3'd0 && !phase_o && !second_cyc_o && ir_latch_o, "R1 mid-run reset",
            {state_o, phase_o, second_cyc_o, ir_latch_o}, 6'b000001);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(state_o == 3'd0 && phase_o && !second_cyc_o, "R1 restart after reset",
            {state_o, phase_o, second_cyc_o}, 5'b00010);

        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

endmodule